// File: doc/BRIEF.md
# Byte-Lane Enable Mask Generator

This block produces the per-byte write/read enable mask for a 128-bit vector datapath. The mask is built from three sources, combined in a fixed order:
- the vector predicate, whose two halves can each be switched to all-active;
- trimming of the final pass of a tail-predicated loop, which drops the lanes beyond the last valid element;
- suppression of beats that an interrupted instruction already completed before it was resumed.

A 1 in the result marks an active byte lane. An 8-bit element uses every bit. A 16-bit element reads the even bits, and a 32-bit element reads bits 0, 4, 8 and 12.

The mask is registered, so the result for a set of inputs appears one clock after they are presented. A separate flag reports a resumed-beat code that has no meaning. A vector load/store or arithmetic pipeline drives this block from its architectural state and feeds the mask to its lane write enables.

Top module: `lane_mask_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `lane_en` becomes 0 and `bad_beat` becomes 0.
- R2: Outputs are registered: `lane_en` and `bad_beat` reflect the inputs sampled at the previous rising edge and do not change between edges.
- R3: The base mask is `pred_reg[15:0]`. If `pred_reg[19:16]` is zero, bits 7:0 are forced to 1. If `pred_reg[23:20]` is zero, bits 15:8 are forced to 1.
- R4: Tail trimming is active only when `tail_size` < 4 and `loop_cnt` <= (1 << (4 - `tail_size`)). Values of `tail_size` from 4 to 7, or any larger count, leave the mask untrimmed.
- R5: When trimming is active, only the low (`loop_cnt` << `tail_size`) bits are kept and all higher bits are cleared. A count of 0 gives an all-zero mask.
- R6: Beat suppression happens only when `cond_lo` is 0. Otherwise `beat_code` has no effect on `lane_en`, and `bad_beat` stays 0.
- R7: With `cond_lo` = 0, the beat codes act as follows:
  - 0 leaves the mask unchanged;
  - 1 clears bits 3:0;
  - 2 clears bits 7:0;
  - 4 and 5 clear bits 11:0.
- R8: With `cond_lo` = 0, codes 3 and 6 to 15 set `bad_beat` to 1 and leave the mask as produced by the predicate and tail stages.
- R9: The stages apply in this order: predicate, then tail, then beat. Lanes forced active by an empty block field are still cleared by tail trimming and by beat suppression.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_reg | input | 24 | Predicate word: lane bits 15:0, low block field 19:16, high block field 23:20 |
| tail_size | input | 3 | Tail element-size code (log2 of element bytes); 4 or more disables trimming |
| loop_cnt | input | 32 | Remaining loop count |
| cond_lo | input | 4 | Low nibble of the condition state; zero enables beat suppression |
| beat_code | input | 4 | Code for the beats already completed |
| lane_en | output | 16 | Registered byte-lane enable mask |
| bad_beat | output | 1 | Registered flag for a meaningless beat code |

## Verification
On every cycle, the assertions check the following:
- the reset values;
- the lanes each beat code must clear;
- an all-zero mask for a zero count when trimming is active;
- that the error flag can only follow a zero condition nibble with an illegal code.

Only the bench's sweeps can show the exact bit patterns. That covers trimming lengths at and beyond the count limit for each size code, and forced halves being cut back by later stages. It also covers beat codes being ignored when the condition nibble is nonzero, and the one-cycle output timing.

// File: rtl/lane_mask_pkg.sv
`timescale 1ns/1ps
package lane_mask_pkg;
  // Codes naming how many beats were finished before resumption
  typedef enum logic [3:0] {
    BEAT_NONE   = 4'd0,
    BEAT_ONE    = 4'd1,
    BEAT_TWO    = 4'd2,
    BEAT_THREE  = 4'd4,
    BEAT_THREEP = 4'd5
  } beat_code_e;

  // Beats already done for a code; legal is cleared for unknown codes
  function automatic logic [2:0] beats_done(input logic [3:0] code,
                                            output logic legal);
    legal = 1'b1;
    case (code)
      BEAT_NONE:               beats_done = 3'd0;
      BEAT_ONE:                beats_done = 3'd1;
      BEAT_TWO:                beats_done = 3'd2;
      BEAT_THREE, BEAT_THREEP: beats_done = 3'd3;
      default: begin
        beats_done = 3'd0;
        legal      = 1'b0;
      end
    endcase
  endfunction
endpackage

// File: rtl/pred_stage.sv
`timescale 1ns/1ps
module pred_stage #(
  parameter int LANES = 16,
  parameter int FLD_W = 4,
  localparam int HALF = LANES / 2,
  localparam int PW   = LANES + 2 * FLD_W
) (
  input  logic [PW-1:0]    pred_reg,
  output logic [LANES-1:0] mask_o
);
  // Each half of the lane predicate is forced active when its field is empty
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic off;
    assign off = (pred_reg[LANES + h*FLD_W +: FLD_W] == '0);
    assign mask_o[h*HALF +: HALF] = off ? {HALF{1'b1}} : pred_reg[h*HALF +: HALF];
  end
endmodule

// File: rtl/tail_stage.sv
`timescale 1ns/1ps
module tail_stage #(
  parameter int LANES = 16,
  parameter int CNT_W = 32,
  localparam int LOG_L = $clog2(LANES),
  localparam int SZ_W  = $clog2(LOG_L) + 1,
  localparam int LEN_W = LOG_L + 1
) (
  input  logic [LANES-1:0] mask_i,
  input  logic [SZ_W-1:0]  tail_size,
  input  logic [CNT_W-1:0] loop_cnt,
  output logic [LANES-1:0] mask_o
);
  logic             size_ok;
  logic [CNT_W-1:0] limit;
  logic             active;
  logic [LEN_W-1:0] keep_len;
  logic [LANES-1:0] keep;

  assign size_ok  = (tail_size < SZ_W'(LOG_L));
  assign limit    = size_ok ? (CNT_W'(1) << (SZ_W'(LOG_L) - tail_size)) : '0;
  assign active   = size_ok && (loop_cnt <= limit);
  // Under active trimming the count fits LEN_W bits and the length is <= LANES
  assign keep_len = loop_cnt[LEN_W-1:0] << tail_size;

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign keep[i] = (LEN_W'(i) < keep_len);
  end

  assign mask_o = active ? (mask_i & keep) : mask_i;
endmodule

// File: rtl/beat_stage.sv
`timescale 1ns/1ps
module beat_stage
  import lane_mask_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BEATS = 4,
  localparam int BEAT_L = LANES / BEATS
) (
  input  logic [LANES-1:0] mask_i,
  input  logic [3:0]       cond_lo,
  input  logic [3:0]       beat_code,
  output logic [LANES-1:0] mask_o,
  output logic             bad_o
);
  logic       enable;
  logic       legal;
  logic [2:0] done;

  always_comb begin
    done = beats_done(beat_code, legal);
  end

  assign enable = (cond_lo == 4'd0);
  assign bad_o  = enable && !legal;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic clr;
    assign clr = enable && (3'(b) < done);
    assign mask_o[b*BEAT_L +: BEAT_L] = clr ? '0 : mask_i[b*BEAT_L +: BEAT_L];
  end
endmodule

// File: rtl/lane_mask_gen.sv
`timescale 1ns/1ps
module lane_mask_gen #(
  parameter int LANES = 16,
  parameter int FLD_W = 4,
  parameter int CNT_W = 32,
  parameter int BEATS = 4,
  localparam int PW     = LANES + 2 * FLD_W,
  localparam int LOG_L  = $clog2(LANES),
  localparam int SZ_W   = $clog2(LOG_L) + 1,
  localparam int BEAT_L = LANES / BEATS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    pred_reg,
  input  logic [SZ_W-1:0]  tail_size,
  input  logic [CNT_W-1:0] loop_cnt,
  input  logic [3:0]       cond_lo,
  input  logic [3:0]       beat_code,
  output logic [LANES-1:0] lane_en,
  output logic             bad_beat
);
  logic [LANES-1:0] m_pred, m_tail, m_beat;
  logic             bad_d;

  pred_stage #(.LANES(LANES), .FLD_W(FLD_W)) u_pred (
    .pred_reg (pred_reg),
    .mask_o   (m_pred)
  );

  tail_stage #(.LANES(LANES), .CNT_W(CNT_W)) u_tail (
    .mask_i    (m_pred),
    .tail_size (tail_size),
    .loop_cnt  (loop_cnt),
    .mask_o    (m_tail)
  );

  beat_stage #(.LANES(LANES), .BEATS(BEATS)) u_beat (
    .mask_i    (m_tail),
    .cond_lo   (cond_lo),
    .beat_code (beat_code),
    .mask_o    (m_beat),
    .bad_o     (bad_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_en  <= '0;
      bad_beat <= 1'b0;
    end else begin
      lane_en  <= m_beat;
      bad_beat <= bad_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (lane_en == '0 && !bad_beat));

  // R7
  beat_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_lo) == 4'd0 && $past(beat_code) == 4'd1)
      |-> lane_en[BEAT_L-1:0] == '0);

  // R7
  beat_two_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_lo) == 4'd0 && $past(beat_code) == 4'd2)
      |-> lane_en[2*BEAT_L-1:0] == '0);

  // R7
  beat_three_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_lo) == 4'd0
     && ($past(beat_code) == 4'd4 || $past(beat_code) == 4'd5))
      |-> lane_en[3*BEAT_L-1:0] == '0);

  // R5
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tail_size) < SZ_W'(LOG_L) && $past(loop_cnt) == '0)
      |-> lane_en == '0);

  // R6 R8
  bad_source_chk: assert property (@(posedge clk) disable iff (rst)
    bad_beat |-> ($past(cond_lo) == 4'd0 && $past(beat_code) != 4'd0
                  && $past(beat_code) != 4'd1 && $past(beat_code) != 4'd2
                  && $past(beat_code) != 4'd4 && $past(beat_code) != 4'd5));
endmodule

// File: tb/test_lane_mask_gen.sv
`timescale 1ns/1ps
module test_lane_mask_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pred_reg = '0;
  logic [2:0]  tail_size = '0;
  logic [31:0] loop_cnt = '0;
  logic [3:0]  cond_lo = '0;
  logic [3:0]  beat_code = '0;
  logic [15:0] lane_en;
  logic        bad_beat;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  lane_mask_gen i_lane_mask_gen (
    .clk(clk), .rst(rst), .pred_reg(pred_reg), .tail_size(tail_size),
    .loop_cnt(loop_cnt), .cond_lo(cond_lo), .beat_code(beat_code),
    .lane_en(lane_en), .bad_beat(bad_beat)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected outputs computed arithmetically from the requirements
  task automatic model(input logic [23:0] p, input int sz, input logic [31:0] cnt,
                       input int cl, input int bc,
                       output logic [15:0] m, output logic bad, output string tag);
    int lim;
    int len;
    bit tact;
    m = p[15:0];
    if (p[19:16] == 4'd0) m = m | 16'h00FF;  // R3
    if (p[23:20] == 4'd0) m = m | 16'hFF00;
    tact = 1'b0;
    if (sz < 4) begin                        // R4
      lim = 1 << (4 - sz);
      if (cnt <= 32'(lim)) begin
        tact = 1'b1;
        len = int'(cnt) << sz;               // R5
        if (len < 16) m = m & 16'((32'd1 << len) - 32'd1);
      end
    end
    bad = 1'b0;
    if (cl == 0) begin                       // R7 R8
      case (bc)
        0: ;
        1: m = m & 16'hFFF0;
        2: m = m & 16'hFF00;
        4, 5: m = m & 16'hF000;
        default: bad = 1'b1;
      endcase
    end
    if (cl == 0 && bc != 0) tag = bad ? "R8" : "R7";
    else if (cl != 0 && bc != 0) tag = "R6";
    else if (tact && (p[19:16] == 4'd0 || p[23:20] == 4'd0)) tag = "R9";
    else if (sz < 4 && (cnt == 32'(1 << (4 - sz)) || cnt == 32'((1 << (4 - sz)) + 1))) tag = "R4";
    else if (tact) tag = "R5";
    else tag = "R3";
  endtask

  task automatic apply_and_check(input logic [23:0] p, input int sz, input logic [31:0] cnt,
                                 input int cl, input int bc);
    logic [15:0] em;
    logic eb;
    string tg;
    model(p, sz, cnt, cl, bc, em, eb, tg);
    pred_reg  = p;
    tail_size = 3'(sz);
    loop_cnt  = cnt;
    cond_lo   = 4'(cl);
    beat_code = 4'(bc);
    @(negedge clk);
    check({tg, " mask"}, 32'(lane_en), 32'(em));
    check("R8 flag", 32'(bad_beat), 32'(eb));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] preds [4];
    logic [15:0] held;
    preds[0] = 24'h000000;
    preds[1] = 24'h11A5C3;
    preds[2] = 24'h0F1234;
    preds[3] = 24'h905A5A;

    pred_reg = 24'hFFFFFF;
    cond_lo  = 4'd0;
    beat_code = 4'd3;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 mask", 32'(lane_en), 32'd0);
    check("R1 flag", 32'(bad_beat), 32'd0);
    rst = 1'b0;

    // R2: output holds until the next rising edge
    apply_and_check(24'h11FFFF, 7, 32'd0, 4'd8, 0);
    held = lane_en;
    pred_reg = 24'h110000;
    #1;
    check("R2 hold", 32'(lane_en), 32'(held));
    @(negedge clk);
    check("R2 update", 32'(lane_en), 32'h0);

    for (int pi = 0; pi < 4; pi++)
      for (int sz = 0; sz < 8; sz++)
        for (int c = 0; c <= 20; c++)
          for (int bc = 0; bc < 16; bc++) begin
            apply_and_check(preds[pi], sz, 32'(c), 0, bc);
            apply_and_check(preds[pi], sz, 32'(c), 8, bc);
          end

    // R4: huge counts never trim
    apply_and_check(24'h000000, 0, 32'hFFFFFFFF, 3, 0);
    apply_and_check(24'h000000, 2, 32'h80000001, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule